// File: doc/BRIEF.md
# Ethernet Receive Frame Check Verifier

This block sits on the receive side of an Ethernet datapath and decides whether each frame arrived intact. Frame bytes arrive one per clock with a valid qualifier and start and end markers. The stream includes the four check bytes that close every frame. Every accepted byte, check bytes included, is folded into a 32-bit CRC register with a byte-wide XOR network. The block never strips the check bytes or replaces them with zeros.

When the final byte has been folded in, the raw register is compared against the fixed remainder that an error-free frame always leaves. On the next cycle a result strobe rises for a single cycle, with a pass or fail flag. The block does not parse preamble, delimiters, addresses or length fields. It also exposes the running register in transmit form (inverted and bit-mirrored), so a transmitter can reuse the same engine to produce the check value.

Top module: `fcs_rx_check`

## Requirements
- R1: Each accepted byte updates the register with generator polynomial 0x04C11DB7 in its MSB-aligned form. Data bits enter least significant bit first (bit 0 of `in_data` first), which is the serial line order.
- R2: A byte accepted with `in_sof` high is folded into an all-ones register rather than into the current contents. This holds even when a previous frame has not ended.
- R3: While `in_valid` is low, the register, the byte count and the result outputs are unaffected, whatever `in_sof`, `in_eof` and `in_data` carry.
- R4: `res_valid` is high for exactly one cycle, the cycle after a byte is accepted with `in_eof` high. It is low at all other times.
- R5: With `res_valid`, `res_ok` is 1 when the raw register, after the last byte, equals 0xC704DD7B and the frame held at least 4 bytes. Otherwise `res_ok` is 0. `res_ok` is never high without `res_valid`.
- R6: A frame of 1, 2 or 3 bytes is always reported with `res_ok` = 0.
- R7: `tx_fcs` bit i equals the inverse of register bit 31-i. After the payload bytes of a frame, `tx_fcs` is the standard CRC-32 of those bytes (the nine ASCII digits "123456789" give 0xCBF43926). On the line that value is sent least significant byte first.
- R8: A single flipped bit anywhere in the payload or the check bytes of a correct frame makes `res_ok` 0.
- R9: After reset, `res_valid` and `res_ok` are 0, and the register holds all ones, so `tx_fcs` reads 0x00000000.
- R10: Because of the all-ones start, a zero byte put in front of an otherwise correct frame makes `res_ok` 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Byte on `in_data` is accepted this cycle |
| in_sof | input | 1 | Accepted byte is the first of a frame |
| in_eof | input | 1 | Accepted byte is the last of a frame |
| in_data | input | 8 | Received byte, bit 0 first on the line |
| res_valid | output | 1 | One-cycle verdict strobe |
| res_ok | output | 1 | Frame check passed, qualified by `res_valid` |
| tx_fcs | output | 32 | Running register in transmit form |

## Verification
The hardest case to reach from the ports is a frame that is wrong by exactly one bit. Random traffic almost never produces one, and a weak update network can still pass most frames. The bench therefore builds a correct frame around a check value from its own reflected software model. It then walks a single flipped bit through all 96 positions of a twelve-byte frame, check bytes included, and expects a failure for each one. Idle cycles carrying live-looking markers, restarts in mid-frame and a prepended zero byte are built the same way, from known-good frames.

// File: rtl/fcs_pkg.sv
package fcs_pkg;

    localparam int CRC_W  = 32;
    localparam int BYTE_W = 8;

    typedef logic [CRC_W-1:0]  crc_t;
    typedef logic [BYTE_W-1:0] byte_t;

    localparam crc_t GEN_POLY     = 32'h04C1_1DB7;
    localparam crc_t SEED_ONES    = '1;
    localparam crc_t GOOD_RESIDUE = 32'hC704_DD7B;

    typedef struct packed {
        logic  sof;
        logic  eof;
        byte_t data;
    } beat_t;

    typedef struct packed {
        logic valid;
        logic ok;
    } verdict_t;

    // Fold one byte, line order (bit 0 first), into an MSB-aligned register.
    function automatic crc_t crc_fold(crc_t cur, byte_t d);
        crc_t r;
        logic fb;
        r = cur;
        for (int i = 0; i < BYTE_W; i++) begin
            fb = r[CRC_W-1] ^ d[i];
            r  = {r[CRC_W-2:0], 1'b0};
            if (fb) r = r ^ GEN_POLY;
        end
        return r;
    endfunction

    // Transmit view: mirrored and inverted.
    function automatic crc_t tx_view(crc_t r);
        crc_t o;
        for (int i = 0; i < CRC_W; i++) o[i] = ~r[CRC_W-1-i];
        return o;
    endfunction

endpackage

// File: rtl/fcs_engine.sv
module fcs_engine
    import fcs_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  take,
    input  beat_t beat,
    output crc_t  crc_q,
    output crc_t  crc_d
);

    crc_t base;

    always_comb begin
        base  = beat.sof ? SEED_ONES : crc_q;
        crc_d = take ? crc_fold(base, beat.data) : crc_q;
    end

    always_ff @(posedge clk) begin
        if (rst) crc_q <= SEED_ONES;
        else     crc_q <= crc_d;
    end

    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !take |=> $stable(crc_q));

    // R2
    restart_seed_chk: assert property (@(posedge clk) disable iff (rst)
        (take && beat.sof && beat.data == '0) |=> crc_q == crc_fold(SEED_ONES, '0));

endmodule

// File: rtl/fcs_len_count.sv
module fcs_len_count #(
    parameter int MIN_LEN = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic take,
    input  logic sof,
    output logic long_enough_d
);

    localparam int CNT_W = $clog2(MIN_LEN + 1);
    localparam logic [CNT_W-1:0] CAP = CNT_W'(MIN_LEN);

    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (take) begin
            if (sof)             cnt_d = CNT_W'(1);
            else if (cnt_q < CAP) cnt_d = cnt_q + CNT_W'(1);
        end
        long_enough_d = (cnt_d >= CAP);
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    // R2
    sof_restart_chk: assert property (@(posedge clk) disable iff (rst)
        (take && sof) |=> cnt_q == CNT_W'(1));

    // R6
    cap_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CAP);

endmodule

// File: rtl/fcs_verdict.sv
module fcs_verdict
    import fcs_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     take,
    input  logic     eof,
    input  crc_t     crc_d,
    input  logic     long_enough_d,
    output verdict_t res_q
);

    verdict_t res_d;

    always_comb begin
        res_d.valid = take && eof;
        res_d.ok    = take && eof && long_enough_d && (crc_d == GOOD_RESIDUE);
    end

    always_ff @(posedge clk) begin
        if (rst) res_q <= '0;
        else     res_q <= res_d;
    end

    // R5
    ok_needs_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        res_q.ok |-> res_q.valid);

    // R4
    strobe_cause_chk: assert property (@(posedge clk) disable iff (rst)
        !(take && eof) |=> !res_q.valid);

endmodule

// File: rtl/fcs_rx_check.sv
module fcs_rx_check
    import fcs_pkg::*;
#(
    parameter int MIN_LEN = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic        in_sof,
    input  logic        in_eof,
    input  logic [7:0]  in_data,
    output logic        res_valid,
    output logic        res_ok,
    output logic [31:0] tx_fcs
);

    beat_t    beat;
    crc_t     crc_q, crc_d;
    logic     long_d;
    verdict_t res;

    assign beat = '{sof: in_sof, eof: in_eof, data: in_data};

    fcs_engine u_engine (
        .clk   (clk),
        .rst   (rst),
        .take  (in_valid),
        .beat  (beat),
        .crc_q (crc_q),
        .crc_d (crc_d)
    );

    fcs_len_count #(.MIN_LEN(MIN_LEN)) u_len (
        .clk           (clk),
        .rst           (rst),
        .take          (in_valid),
        .sof           (in_sof),
        .long_enough_d (long_d)
    );

    fcs_verdict u_verdict (
        .clk           (clk),
        .rst           (rst),
        .take          (in_valid),
        .eof           (in_eof),
        .crc_d         (crc_d),
        .long_enough_d (long_d),
        .res_q         (res)
    );

    assign res_valid = res.valid;
    assign res_ok    = res.ok;
    assign tx_fcs    = tx_view(crc_q);

    // R6
    one_byte_frame_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_sof && in_eof) |=> !res_ok);

    // R3
    idle_no_verdict_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !res_valid);

endmodule

// File: tb/sim_fcs_rx_check.sv
`timescale 1ns/1ps
module sim_fcs_rx_check;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid, in_sof, in_eof;
    logic [7:0]  in_data;
    logic        res_valid, res_ok;
    logic [31:0] tx_fcs;

    int checks = 0;
    int fails  = 0;

    logic [7:0] fr [0:63];
    int         flen;

    always #2.5 clk = ~clk;

    fcs_rx_check u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sof(in_sof),
        .in_eof(in_eof), .in_data(in_data), .res_valid(res_valid),
        .res_ok(res_ok), .tx_fcs(tx_fcs)
    );

    task automatic chk(input bit good, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!good) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    // Reflected software model; returns the value sent on the line.
    function automatic logic [31:0] ref_fcs(int n);
        logic [31:0] c = 32'hFFFF_FFFF;
        for (int i = 0; i < n; i++) begin
            c = c ^ {24'h0, fr[i]};
            for (int b = 0; b < 8; b++)
                c = c[0] ? ((c >> 1) ^ 32'hEDB8_8320) : (c >> 1);
        end
        return ~c;
    endfunction

    task automatic build_good(input int plen, input int seed);
        logic [31:0] f;
        for (int i = 0; i < plen; i++) fr[i] = 8'((seed * 31 + i * 7) ^ (i << 3) ^ seed);
        f = ref_fcs(plen);
        for (int j = 0; j < 4; j++) fr[plen + j] = f[8*j +: 8];
        flen = plen + 4;
    endtask

    task automatic drive(input logic v, input logic s, input logic e, input logic [7:0] d);
        in_valid = v; in_sof = s; in_eof = e; in_data = d;
    endtask

    task automatic run_frame(input int n, input int plen, input logic exp_ok, input bit gaps, input string tag);
        bit early;
        early = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (i > 0 && res_valid) early = 1;
            if (plen > 0 && i == plen)
                chk(tx_fcs == ref_fcs(plen), "R7 tx_fcs after payload", tx_fcs, ref_fcs(plen));
            drive(1'b1, i == 0, i == n - 1, fr[i]);
            if (gaps && i < n - 1) begin
                @(negedge clk);
                if (res_valid) early = 1;
                drive(1'b0, 1'b1, 1'b1, 8'hA5);  // R3: markers on idle cycle
            end
        end
        @(negedge clk);
        chk(res_valid == 1'b1, "R4 strobe after last byte", {31'h0, res_valid}, 32'h1);
        chk(res_ok == exp_ok, tag, {31'h0, res_ok}, {31'h0, exp_ok});
        drive(1'b0, 1'b0, 1'b0, 8'h00);
        @(negedge clk);
        chk(res_valid == 1'b0, "R4 strobe lasts one cycle", {31'h0, res_valid}, 32'h0);
        chk(!early, gaps ? "R3 no strobe on idle cycles" : "R4 no strobe mid-frame", {31'h0, early}, 32'h0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        string s9;
        rst = 1'b1;
        drive(1'b0, 1'b0, 1'b0, 8'h00);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R9 reset state
        chk(res_valid == 1'b0, "R9 res_valid after reset", {31'h0, res_valid}, 32'h0);
        chk(res_ok == 1'b0, "R9 res_ok after reset", {31'h0, res_ok}, 32'h0);
        chk(tx_fcs == 32'h0, "R9 tx_fcs after reset", tx_fcs, 32'h0);

        // R1 R7 known check string
        s9 = "123456789";
        for (int i = 0; i < 9; i++) fr[i] = s9[i];
        chk(ref_fcs(9) == 32'hCBF4_3926, "R7 bench model sanity", ref_fcs(9), 32'hCBF4_3926);
        begin
            logic [31:0] f;
            f = ref_fcs(9);
            for (int j = 0; j < 4; j++) fr[9 + j] = f[8*j +: 8];
        end
        run_frame(13, 9, 1'b1, 0, "R1 R5 check string frame passes");

        // R5 correct frames of many payload lengths, including empty payload
        for (int p = 0; p <= 40; p++) begin
            build_good(p, p + 3);
            run_frame(flen, p, 1'b1, 0, "R5 good frame passes");
        end

        // R8 every single-bit error in a 12-byte frame
        for (int k = 0; k < 96; k++) begin
            build_good(8, 77);
            fr[k / 8][k % 8] = ~fr[k / 8][k % 8];
            run_frame(flen, -1, 1'b0, 0, "R8 flipped bit detected");
        end

        // R6 short frames
        for (int n = 1; n <= 3; n++) begin
            for (int i = 0; i < n; i++) fr[i] = 8'(n * 17 + i);
            run_frame(n, -1, 1'b0, 0, "R6 short frame fails");
        end

        // R10 zero byte in front of a correct frame
        build_good(6, 9);
        for (int i = flen; i > 0; i--) fr[i] = fr[i - 1];
        fr[0] = 8'h00;
        run_frame(flen + 1, -1, 1'b0, 0, "R10 leading zero detected");

        // R3 idle cycles carrying markers inside a frame
        build_good(10, 41);
        run_frame(flen, 10, 1'b1, 1, "R3 gapped frame passes");

        // R2 restart in mid-frame: abandoned partial frame, then a good one
        @(negedge clk);
        for (int i = 0; i < 5; i++) begin
            drive(1'b1, i == 0, 1'b0, 8'(8'hC3 + i));
            @(negedge clk);
        end
        build_good(12, 5);
        run_frame(flen, 12, 1'b1, 0, "R2 restart reloads seed");

        summary();
        $finish;
    end

endmodule